// File: doc/BRIEF.md
# Knock Window Integrator

This block turns a stream of signed, band-filtered vibration samples into one energy figure per measurement window. Each sample that arrives with its strobe is converted to its magnitude (full-wave rectification), scaled by a rate set from a 5-bit time-constant code, and added to a fixed-point accumulator. The accumulator runs only while the window input is high. It freezes while that input is low, and it is cleared when a new window opens.

The 10-bit integer part of the accumulator is the block's result. It feeds both a digital-to-analog converter and a serial readback path. When the result would exceed full scale it sticks at 1023 and raises a clamp flag. The flag stays set until the next window opens. A host typically sets the time-constant code, opens the window around the combustion event, closes it, and then reads the held value.

Top module: `knk_integrator`

## Requirements
- R1: A sample with a negative value contributes exactly as much as the positive sample of the same magnitude (the most negative code -2048 counts as magnitude 2048).
- R2: While `int_hold_i` is sampled low at a clock edge, `value_o` and `clamp_o` do not change at that edge, whatever the sample strobe and data do.
- R3: The first clock edge at which `int_hold_i` is high after being low starts a window: the accumulator and `clamp_o` are cleared. A sample strobed at that same edge is the first sample of the new window.
- R4: Code c selects the time constant τ in µs: 40+5c for c 0..7, 80+10(c-8) for 8..16, 160+20(c-16) for 17..24, and 320+40(c-24) for 25..31. The rate word is R = round(327680/τ). Each integrated sample adds floor(|x|·R/4) to a 24-bit accumulator whose upper 10 bits are `value_o`. The code is taken per sample.
- R5: When an addition would reach 1024·2^14 or more, the accumulator is set to all ones, so `value_o` is 1023, and `clamp_o` rises.
- R6: Once set, `clamp_o` stays high until the next window start.
- R7: After reset, `value_o` is 0 and `clamp_o` is 0.
- R8: During a window, `value_o` reflects a strobed sample at the first output sample after the clock edge that takes it. Data presented without the strobe changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_dat_i | input | 12 | Signed two's-complement filtered sample |
| int_hold_i | input | 1 | High integrates, low holds; a rising level opens a window |
| tc_code_i | input | 5 | Time-constant code |
| value_o | output | 10 | Integrated result, saturating |
| clamp_o | output | 1 | Saturation occurred in this window |

## Verification
The assertions check the following on every cycle:
- the output is frozen whenever the window input is low;
- the result never falls inside a window, because the integrand is a magnitude;
- a sampleless window start clears both the result and the flag;
- the clamp flag always comes with a full-scale result and persists until the next window start.

Only the bench scenarios can show the exact increments per time-constant code. They also show the equal weight of negative and positive samples, including the most negative code, and the point at which saturation is reached.

// File: rtl/knk_pkg.sv
package knk_pkg;

    localparam int SMP_W  = 12;
    localparam int OUT_W  = 10;
    localparam int FRAC_W = 14;
    localparam int RCP_W  = 16;
    localparam int CODE_W = 5;
    localparam int NCODE  = 1 << CODE_W;
    localparam int ACC_W  = OUT_W + FRAC_W;
    localparam int PROD_W = SMP_W + RCP_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int SHIFT  = RCP_W - FRAC_W;
    // 5 us sample period scaled by 2^16
    localparam int RATE_NUM = 5 * 65536;

    typedef struct packed {
        logic                    vld;
        logic signed [SMP_W-1:0] val;
    } knk_smp_t;

    typedef struct packed {
        logic             vld;
        logic [SMP_W-1:0] mag;
    } knk_mag_t;

    typedef struct packed {
        logic [OUT_W-1:0] value;
        logic             clamp;
    } knk_res_t;

    // time constant in microseconds for a code
    function automatic int knk_tau_us(input int c);
        if (c < 8)       return 40 + 5 * c;
        else if (c < 17) return 80 + 10 * (c - 8);
        else if (c < 25) return 160 + 20 * (c - 16);
        else             return 320 + 40 * (c - 24);
    endfunction

    function automatic logic [RCP_W-1:0] knk_rate(input int c);
        int t;
        t = knk_tau_us(c);
        return RCP_W'((RATE_NUM + t / 2) / t);
    endfunction

endpackage

// File: rtl/knk_rectify.sv
module knk_rectify
    import knk_pkg::*;
(
    input  knk_smp_t smp_i,
    output knk_mag_t mag_o
);
    logic [SMP_W-1:0] neg;

    always_comb begin
        neg        = SMP_W'(-smp_i.val);
        mag_o.vld  = smp_i.vld;
        mag_o.mag  = smp_i.val[SMP_W-1] ? neg : smp_i.val;
    end
endmodule

// File: rtl/knk_rate_lut.sv
module knk_rate_lut
    import knk_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [RCP_W-1:0]  rate_o
);
    logic [RCP_W-1:0] tbl [NCODE];

    for (genvar i = 0; i < NCODE; i++) begin : g_ent
        assign tbl[i] = knk_rate(i);
    end

    assign rate_o = tbl[code_i];
endmodule

// File: rtl/knk_accum.sv
module knk_accum
    import knk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  knk_mag_t         mag_i,
    input  logic [RCP_W-1:0] rate_i,
    input  logic             run_i,
    input  logic             start_i,
    output knk_res_t         res_o
);
    localparam logic [SUM_W-1:0] FULL = SUM_W'(1) << ACC_W;

    logic [ACC_W-1:0]  acc_q;
    logic              clamp_q;
    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  base, sum;

    always_comb begin
        prod = PROD_W'(mag_i.mag) * PROD_W'(rate_i);
        base = start_i ? '0 : SUM_W'(acc_q);
        sum  = base + SUM_W'(prod >> SHIFT);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q   <= '0;
            clamp_q <= 1'b0;
        end else if (run_i) begin
            if (start_i) clamp_q <= 1'b0;
            if (mag_i.vld) begin
                if (sum >= FULL) begin
                    acc_q   <= '1;
                    clamp_q <= 1'b1;
                end else begin
                    acc_q <= sum[ACC_W-1:0];
                end
            end else if (start_i) begin
                acc_q <= '0;
            end
        end
    end

    assign res_o.value = acc_q[ACC_W-1 -: OUT_W];
    assign res_o.clamp = clamp_q;
endmodule

// File: rtl/knk_integrator.sv
module knk_integrator
    import knk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              smp_vld_i,
    input  logic [SMP_W-1:0]  smp_dat_i,
    input  logic              int_hold_i,
    input  logic [CODE_W-1:0] tc_code_i,
    output logic [OUT_W-1:0]  value_o,
    output logic              clamp_o
);
    knk_smp_t         smp;
    knk_mag_t         mag;
    knk_res_t         res;
    logic [RCP_W-1:0] rate;
    logic             win_q;
    logic             start;

    assign smp.vld = smp_vld_i;
    assign smp.val = smp_dat_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) win_q <= 1'b0;
        else       win_q <= int_hold_i;
    end

    assign start = int_hold_i & ~win_q;

    knk_rectify u_rect (.smp_i(smp), .mag_o(mag));

    knk_rate_lut u_lut (.code_i(tc_code_i), .rate_o(rate));

    knk_accum u_acc (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .mag_i  (mag),
        .rate_i (rate),
        .run_i  (int_hold_i),
        .start_i(start),
        .res_o  (res)
    );

    assign value_o = res.value;
    assign clamp_o = res.clamp;
endmodule

// File: rtl/knk_integrator_chk.sv
module knk_integrator_chk
    import knk_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             smp_vld_i,
    input logic             int_hold_i,
    input logic [OUT_W-1:0] value_o,
    input logic             clamp_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= int_hold_i;
    end

    // R2: frozen while holding
    p_hold_frozen_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !int_hold_i |=> ($stable(value_o) && $stable(clamp_o)));

    // R1: magnitudes only, so no decrease inside a window
    p_no_decrease_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (int_hold_i && prev_q) |=> (value_o >= $past(value_o)));

    // R3: empty window start clears result and flag
    p_window_clear_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (int_hold_i && !prev_q && !smp_vld_i) |=> (value_o == '0 && !clamp_o));

    // R5: flag implies full scale
    p_clamp_full_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        clamp_o |-> (value_o == {OUT_W{1'b1}}));

    // R6: flag persists until a window start
    p_clamp_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (clamp_o && !(int_hold_i && !prev_q)) |=> clamp_o);
endmodule

bind knk_integrator knk_integrator_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .smp_vld_i (smp_vld_i),
    .int_hold_i(int_hold_i),
    .value_o   (value_o),
    .clamp_o   (clamp_o)
);

// File: tb/sim_knk_integrator.sv
`timescale 1ns/1ps
module sim_knk_integrator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [11:0] dat = '0;
    logic        ih  = 1'b0;
    logic [4:0]  code = '0;
    logic [9:0]  value;
    logic        clamp;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    longint acc_m = 0;
    bit   clamp_m = 0;

    // time constants in us per code
    int tau_tab [32] = '{40,45,50,55,60,65,70,75,80,90,100,110,120,130,140,150,
                         160,180,200,220,240,260,280,300,320,360,400,440,480,520,560,600};

    always #5 clk = ~clk;

    knk_integrator u0 (
        .clk_i(clk), .rst_i(rst), .smp_vld_i(vld), .smp_dat_i(dat),
        .int_hold_i(ih), .tc_code_i(code), .value_o(value), .clamp_o(clamp)
    );

    function automatic longint rate_of(input int c);
        return (longint'(327680) + tau_tab[c] / 2) / tau_tab[c];
    endfunction

    function automatic void model_add(input int x, input int c);
        longint m;
        m = (x < 0) ? -x : x;
        acc_m = acc_m + (m * rate_of(c)) / 4;
        if (acc_m >= (longint'(1) << 24)) begin
            acc_m   = (longint'(1) << 24) - 1;
            clamp_m = 1;
        end
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        check({req, " value"}, int'(value), int'(acc_m >> 14));
        check({req, " clamp"}, int'(clamp), int'(clamp_m));
    endtask

    // one strobed sample; result sampled at the following negedge
    task automatic send(input int x);
        vld = 1'b1;
        dat = 12'(x);
        @(negedge clk);
        vld = 1'b0;
        if (ih) model_add(x, int'(code));
    endtask

    task automatic open_window();
        ih = 1'b1;
        @(negedge clk);
        acc_m = 0;
        clamp_m = 0;
    endtask

    task automatic close_window();
        ih = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R7 value", int'(value), 0);
        check("R7 clamp", int'(clamp), 0);
    endtask

    task automatic t_basic();
        code = 5'd0;
        open_window();
        check_model("R3 open");
        send(1000);
        check_model("R8 first");
        send(321);
        check_model("R8 second");
        close_window();
    endtask

    task automatic t_negative();
        int pos_v;
        code = 5'd10;
        open_window();
        send(700);
        send(700);
        pos_v = int'(value);
        open_window_again();
        send(-700);
        send(-700);
        check("R1 sign", int'(value), pos_v);
        check_model("R1 model");
        send(-2048);
        check_model("R1 most negative");
        close_window();
    endtask

    task automatic open_window_again();
        close_window();
        open_window();
    endtask

    task automatic t_hold();
        int held;
        code = 5'd3;
        open_window();
        send(1500);
        close_window();
        held = int'(value);
        send(2000);
        send(-900);
        check("R2 hold value", int'(value), held);
        check("R2 hold clamp", int'(clamp), 0);
    endtask

    task automatic t_codes();
        open_window();
        code = 5'd3;  send(1000); check_model("R4 code3");
        code = 5'd25; send(1800); check_model("R4 code25");
        code = 5'd31; send(2047); check_model("R4 code31");
        code = 5'd17; send(-1234); check_model("R4 code17");
        close_window();
    endtask

    task automatic t_nostrobe();
        int v;
        code = 5'd8;
        open_window();
        send(900);
        v = int'(value);
        dat = 12'd2000;
        repeat (4) @(negedge clk);
        check("R8 no strobe", int'(value), v);
        close_window();
    endtask

    task automatic t_saturate();
        code = 5'd0;
        open_window();
        for (int i = 0; i < 6; i++) begin
            send(2047);
            check_model("R5 ramp");
        end
        check("R5 full", int'(value), 1023);
        check("R5 flag", int'(clamp), 1);
        send(100);
        check("R6 sticky in window", int'(clamp), 1);
        close_window();
        repeat (3) @(negedge clk);
        check("R6 sticky in hold", int'(clamp), 1);
        open_window();
        check("R3 clamp cleared", int'(clamp), 0);
        check("R3 value cleared", int'(value), 0);
        close_window();
    endtask

    task automatic t_start_with_sample();
        code = 5'd14;
        ih  = 1'b1;
        vld = 1'b1;
        dat = 12'd1111;
        @(negedge clk);
        vld = 1'b0;
        acc_m = 0;
        clamp_m = 0;
        model_add(1111, 14);
        check_model("R3 sample at start");
        close_window();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_negative();
        t_hold();
        t_codes();
        t_nostrobe();
        t_saturate();
        t_start_with_sample();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule